// File: doc/BRIEF.md
# Seven-Channel Cascaded DMA Controller

This block is a fly-by DMA engine for legacy-style peripherals. Its eight channel slots form two four-slot engines. Slots 0 to 3 move bytes. Slots 5 to 7 move 16-bit words. Slot 4 is not a transfer channel. It links the lower engine into the upper one and marks bus ownership by the lower engine. Each usable channel has a request input and an acknowledge output, plus a current address, a current count and a mode register.

Software programs the channels through an 8-bit register port. The 16-bit address and count registers are reached one byte at a time through a shared byte-order pointer. Every register can be read back, so software can save the controller state and later restore it. Transfers appear on a strobe interface: a memory read or write strobe, a matching I/O strobe, an address and a width flag. No data passes through the block.

A channel can run in single mode, which releases the bus after each transfer, or in demand mode, which keeps transferring while the request stays high. In verify mode the channel steps its registers but raises no strobes. A channel marked fast skips the setup cycle. At most two channels may be marked fast.

Top module: `dma7Ctrl`

## Requirements
- R1: After reset, all address, count, mode and status registers read zero, every acknowledge and strobe is low, and the byte pointer selects the low byte.
- R2: Each read or write of an address or count field uses the byte the pointer selects (low first) and then flips the pointer. A write to slot 4 field 0 returns the pointer to low.
- R3: The mode register reads back as written, except for the fast bit (see R11). Its bits are: [1:0] kind (01 write: ioRd+memWr, 10 read: memRd+ioWr, 00 or 11 verify), [2] demand, [3] address decrement, [4] fast, [5] enable. Bits [7:6] read zero.
- R4: Among enabled, requesting channels, the lowest-numbered one wins. A request on slot 4 is never granted. dack[4] is high whenever a channel 0 to 3 owns the bus.
- R5: A normal channel spends one setup cycle with only its acknowledge high, then one transfer cycle. A fast channel goes to the transfer cycle in the first cycle after it is granted.
- R6: In single mode the acknowledge drops after each transfer cycle. In demand mode, transfer cycles follow back to back while the request stays high and terminal count has not been reached.
- R7: Each transfer cycle raises the strobes for the mode kind, or none for verify, and presents the current address. Afterwards the address steps by one (down if bit 3 is set) and the count drops by one.
- R8: xferWide is high during transfers of channels 5 to 7 and low for channels 0 to 3.
- R9: A transfer with count zero is the terminal one. In that cycle tcPulse is high. After it the count reads 0xFFFF, the channel status bit is set, the enable bit is cleared and the acknowledge drops.
- R10: Slot 4 field 1 reads the status bits (bit n = channel n). A write there clears them. If a terminal count and a clear happen in the same cycle, the status bit stays set.
- R11: A mode write whose fast bit is set stores that bit as zero when two other channels already have it set.
- R12: regAddr is {slot[4:2], field[1:0]}. Field 0 is the address, 1 the count, 2 the mode. Field 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (advances byte pointer) |
| regAddr | input | 5 | Slot and field select |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected field |
| dreq | input | 8 | Per-slot transfer requests |
| dack | output | 8 | Per-slot acknowledges |
| xferAddr | output | 16 | Current address of the owning channel |
| xferWide | output | 1 | High for a word transfer |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| ioRd | output | 1 | I/O read strobe |
| ioWr | output | 1 | I/O write strobe |
| tcPulse | output | 1 | High in a terminal transfer cycle |

## Verification
A transfer that reaches terminal count sets a status bit, while a software write to the status field clears all of them. The two can fall in the same clock edge. The bench arms a fast single-mode channel with a zero count and raises its request. In the transfer cycle, where tcPulse is seen high, it also drives the status-clear write. It then reads the status field and expects that channel's bit still set. A further clear, with no transfer running, is expected to leave zero.

// File: rtl/dma7_pkg.sv
package dma7_pkg;
  localparam int NCH      = 8;
  localparam int CH_W     = $clog2(NCH);
  localparam int BUS_SLOT = 4;

  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_CNT  = 2'd1;
  localparam logic [1:0] FLD_MODE = 2'd2;

  localparam logic [1:0] KIND_WR = 2'b01;
  localparam logic [1:0] KIND_RD = 2'b10;

  typedef struct packed {
    logic       enable;
    logic       fast;
    logic       down;
    logic       demand;
    logic [1:0] kind;
  } mode_t;

  typedef struct packed {
    logic            step;
    logic [CH_W-1:0] chan;
  } dpCtl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_XFER} xstate_e;
endpackage

// File: rtl/dma7Datapath.sv
module dma7Datapath
  import dma7_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int MAX_FAST = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [4:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  dpCtl_t            ctl,
  output mode_t             chanMode [NCH],
  output logic              selCntZero,
  output logic [ADDR_W-1:0] selAddr
);
  localparam int FC_W = $clog2(NCH + 1);

  logic [CH_W-1:0]   selChan;
  logic [1:0]        fld;
  logic              bytePtr;
  logic [NCH-1:0]    tcStat, tcSet, fastVec;
  logic [ADDR_W-1:0] addrArr [NCH];
  logic [ADDR_W-1:0] cntArr  [NCH];
  logic [FC_W-1:0]   fastOthers;
  mode_t             newMode;
  logic              ptrHit, ptrClr, statClr;

  assign selChan = regAddr[4:2];
  assign fld     = regAddr[1:0];
  assign ptrHit  = (regWr || regRd) && (selChan != CH_W'(BUS_SLOT)) &&
                   (fld == FLD_ADDR || fld == FLD_CNT);
  assign ptrClr  = regWr && selChan == CH_W'(BUS_SLOT) && fld == FLD_ADDR;
  assign statClr = regWr && selChan == CH_W'(BUS_SLOT) && fld == FLD_CNT;

  always_comb begin
    fastOthers = '0;
    for (int i = 0; i < NCH; i++)
      if (fastVec[i] && CH_W'(i) != selChan) fastOthers = fastOthers + 1'b1;
    newMode = mode_t'(regWdata[5:0]);
    if (newMode.fast && fastOthers >= FC_W'(MAX_FAST)) newMode.fast = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       bytePtr <= 1'b0;
    else if (ptrClr) bytePtr <= 1'b0;
    else if (ptrHit) bytePtr <= ~bytePtr;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    if (c == BUS_SLOT) begin : g_link
      assign addrArr[c]  = '0;
      assign cntArr[c]   = '0;
      assign chanMode[c] = '0;
      assign tcSet[c]    = 1'b0;
      assign fastVec[c]  = 1'b0;
    end else begin : g_xfer
      logic [ADDR_W-1:0] addrR, cntR;
      mode_t             modeR;
      logic              stepHere, wrHere;
      assign stepHere = ctl.step && ctl.chan == CH_W'(c);
      assign wrHere   = regWr && selChan == CH_W'(c);
      always_ff @(posedge clk) begin
        if (!rstN) begin
          addrR <= '0;
          cntR  <= '0;
          modeR <= '0;
        end else begin
          if (stepHere) begin
            addrR <= modeR.down ? addrR - 1'b1 : addrR + 1'b1;
            cntR  <= cntR - 1'b1;
            if (cntR == '0) modeR.enable <= 1'b0;
          end
          if (wrHere) begin
            case (fld)
              FLD_ADDR: addrR[{bytePtr, 3'b000} +: 8] <= regWdata;
              FLD_CNT:  cntR[{bytePtr, 3'b000} +: 8]  <= regWdata;
              FLD_MODE: modeR <= newMode;
              default: ;
            endcase
          end
        end
      end
      assign addrArr[c]  = addrR;
      assign cntArr[c]   = cntR;
      assign chanMode[c] = modeR;
      assign tcSet[c]    = stepHere && cntR == '0;
      assign fastVec[c]  = modeR.fast;

      // R9
      tc_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
        (stepHere && cntR == '0 && !wrHere) |=> (cntR == '1 && !modeR.enable));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) tcStat <= '0;
    else       tcStat <= (statClr ? '0 : tcStat) | tcSet;
  end

  always_comb begin
    regRdata = '0;
    if (selChan == CH_W'(BUS_SLOT)) begin
      if (fld == FLD_CNT) regRdata = tcStat;
    end else begin
      case (fld)
        FLD_ADDR: regRdata = addrArr[selChan][{bytePtr, 3'b000} +: 8];
        FLD_CNT:  regRdata = cntArr[selChan][{bytePtr, 3'b000} +: 8];
        FLD_MODE: regRdata = {2'b00, chanMode[selChan]};
        default:  regRdata = '0;
      endcase
    end
  end

  assign selAddr    = addrArr[ctl.chan];
  assign selCntZero = cntArr[ctl.chan] == '0;

  // R11
  fast_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(fastVec) <= MAX_FAST);

  // R10
  tc_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|tcSet) |=> ((tcStat & $past(tcSet)) == $past(tcSet)));
endmodule

// File: rtl/dma7Control.sv
module dma7Control
  import dma7_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] dreq,
  input  mode_t          chanMode [NCH],
  input  logic           selCntZero,
  output dpCtl_t         ctl,
  output logic [NCH-1:0] dack,
  output logic           memRd,
  output logic           memWr,
  output logic           ioRd,
  output logic           ioWr,
  output logic           xferWide,
  output logic           tcPulse
);
  localparam logic [NCH-1:0] LINK_MASK = NCH'(1) << BUS_SLOT;

  xstate_e         state;
  logic [CH_W-1:0] chanQ, win;
  logic [NCH-1:0]  reqVec;
  logic            inX, stayDemand;
  logic [1:0]      kind;

  for (genvar c = 0; c < NCH; c++) begin : g_req
    if (c == BUS_SLOT) begin : g_link
      assign reqVec[c] = 1'b0;
    end else begin : g_use
      assign reqVec[c] = dreq[c] && chanMode[c].enable;
    end
  end

  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (reqVec[i]) win = CH_W'(i);
  end

  assign stayDemand = chanMode[chanQ].demand && reqVec[chanQ] && !selCntZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      chanQ <= '0;
    end else begin
      case (state)
        ST_IDLE:
          if (|reqVec) begin
            chanQ <= win;
            state <= chanMode[win].fast ? ST_XFER : ST_SETUP;
          end
        ST_SETUP: state <= ST_XFER;
        ST_XFER:  state <= stayDemand ? ST_XFER : ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign inX      = state == ST_XFER;
  assign kind     = chanMode[chanQ].kind;
  assign memWr    = inX && kind == KIND_WR;
  assign ioRd     = inX && kind == KIND_WR;
  assign memRd    = inX && kind == KIND_RD;
  assign ioWr     = inX && kind == KIND_RD;
  assign xferWide = inX && chanQ > CH_W'(BUS_SLOT);
  assign tcPulse  = inX && selCntZero;
  assign ctl      = '{step: inX, chan: chanQ};

  always_comb begin
    dack = '0;
    if (state != ST_IDLE) begin
      dack[chanQ] = 1'b1;
      if (chanQ < CH_W'(BUS_SLOT)) dack[BUS_SLOT] = 1'b1;
    end
  end

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dack & ~LINK_MASK));

  // R4
  link_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    dack[BUS_SLOT] |-> (|dack[BUS_SLOT-1:0]));

  // R5
  setup_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP) |=> (state == ST_XFER));

  // R9
  tc_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |=> (state == ST_IDLE));
endmodule

// File: rtl/dma7Ctrl.sv
module dma7Ctrl
  import dma7_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int MAX_FAST = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [4:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic [NCH-1:0]    dreq,
  output logic [NCH-1:0]    dack,
  output logic [ADDR_W-1:0] xferAddr,
  output logic              xferWide,
  output logic              memRd,
  output logic              memWr,
  output logic              ioRd,
  output logic              ioWr,
  output logic              tcPulse
);
  dpCtl_t ctl;
  mode_t  chanMode [NCH];
  logic   selCntZero;

  dma7Datapath #(.ADDR_W(ADDR_W), .MAX_FAST(MAX_FAST)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ctl(ctl), .chanMode(chanMode),
    .selCntZero(selCntZero), .selAddr(xferAddr)
  );

  dma7Control u_ctl (
    .clk(clk), .rstN(rstN), .dreq(dreq), .chanMode(chanMode),
    .selCntZero(selCntZero), .ctl(ctl), .dack(dack), .memRd(memRd),
    .memWr(memWr), .ioRd(ioRd), .ioWr(ioWr), .xferWide(xferWide),
    .tcPulse(tcPulse)
  );
endmodule

// File: tb/dma7Ctrl_tb_top.sv
module dma7Ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic [7:0]  dreq = '0;
  logic [7:0]  dack;
  logic [15:0] xferAddr;
  logic        xferWide, memRd, memWr, ioRd, ioWr, tcPulse;

  int checks = 0;
  int fails  = 0;
  logic [20:0] expQ [$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma7Ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dreq(dreq), .dack(dack),
    .xferAddr(xferAddr), .xferWide(xferWide), .memRd(memRd), .memWr(memWr),
    .ioRd(ioRd), .ioWr(ioWr), .tcPulse(tcPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] item(input logic [15:0] a, input logic w,
                                       input logic mr, input logic mw,
                                       input logic ir, input logic iw);
    return {a, w, mr, mw, ir, iw};
  endfunction

  // monitor: pops the scoreboard on every strobed cycle (R7, R8, R4)
  always @(negedge clk) begin
    if (rstN && (memRd || memWr || ioRd || ioWr)) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R7: actual unexpected transfer %h expected none",
                 item(xferAddr, xferWide, memRd, memWr, ioRd, ioWr));
      end else begin
        logic [20:0] e;
        e = expQ.pop_front();
        if (item(xferAddr, xferWide, memRd, memWr, ioRd, ioWr) !== e) begin
          fails++;
          $display("FAIL R7/R8: actual %h expected %h",
                   item(xferAddr, xferWide, memRd, memWr, ioRd, ioWr), e);
        end
      end
    end
  end

  task automatic regWrite(input logic [2:0] ch, input logic [1:0] f, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = {ch, f}; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] ch, input logic [1:0] f, output logic [7:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = {ch, f};
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic writeWord(input logic [2:0] ch, input logic [1:0] f, input logic [15:0] v);
    regWrite(ch, f, v[7:0]);
    regWrite(ch, f, v[15:8]);
  endtask

  task automatic readWord(input logic [2:0] ch, input logic [1:0] f, output logic [15:0] v);
    logic [7:0] lo, hi;
    regRead(ch, f, lo);
    regRead(ch, f, hi);
    v = {hi, lo};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 dack", dack, 8'h00);
    check("R1 strobes", {memRd, memWr, ioRd, ioWr}, 4'h0);
    readWord(3'd0, 2'd0, w); check("R1 addr", w, 16'h0000);
    regRead(3'd4, 2'd1, b);  check("R1 status", b, 8'h00);

    // R2 / R12 byte ordering, R3 mode readback
    writeWord(3'd1, 2'd0, 16'h1234);
    writeWord(3'd1, 2'd1, 16'h0002);
    regRead(3'd1, 2'd0, b); check("R2 low byte first", b, 8'h34);
    regRead(3'd1, 2'd0, b); check("R2 high byte second", b, 8'h12);
    regRead(3'd1, 2'd0, b); check("R2 pointer flip", b, 8'h34);
    regWrite(3'd4, 2'd0, 8'h00);
    regRead(3'd1, 2'd0, b); check("R2 pointer clear", b, 8'h34);
    regRead(3'd1, 2'd0, b); check("R2 high after clear", b, 8'h12);
    regWrite(3'd1, 2'd2, 8'h21);
    regRead(3'd1, 2'd2, b); check("R3 mode readback", b, 8'h21);
    regRead(3'd1, 2'd3, b); check("R12 field3 zero", b, 8'h00);

    // R5 normal timing, R6 single, R7 write kind, R9 tc
    expQ.push_back(item(16'h1234, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
    expQ.push_back(item(16'h1235, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
    expQ.push_back(item(16'h1236, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
    @(negedge clk); dreq[1] = 1'b1;
    @(negedge clk);
    check("R5 setup dack", dack, 8'h12);
    check("R5 setup no strobe", {memRd, memWr, ioRd, ioWr}, 4'h0);
    @(negedge clk);
    check("R5 xfer strobe", memWr, 1'b1);
    @(negedge clk);
    check("R6 single release", dack, 8'h00);
    idle(12);
    dreq[1] = 1'b0;
    check("R9 queue drained ch1", expQ.size(), 0);
    readWord(3'd1, 2'd1, w); check("R9 count wrap", w, 16'hFFFF);
    readWord(3'd1, 2'd0, w); check("R7 addr increment", w, 16'h1237);
    regRead(3'd1, 2'd2, b);  check("R9 enable cleared", b, 8'h01);
    regRead(3'd4, 2'd1, b);  check("R9 status bit", b, 8'h02);

    // R5 fast, R6 demand, R7 decrement + read kind, R8 width
    writeWord(3'd5, 2'd0, 16'h0100);
    writeWord(3'd5, 2'd1, 16'h0001);
    regWrite(3'd5, 2'd2, 8'h3E);
    regRead(3'd5, 2'd2, b); check("R3 mode ch5", b, 8'h3E);
    expQ.push_back(item(16'h0100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
    expQ.push_back(item(16'h00FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
    @(negedge clk); dreq[5] = 1'b1;
    @(negedge clk);
    check("R5 fast direct xfer", memRd, 1'b1);
    check("R8 wide", xferWide, 1'b1);
    check("R4 no link for upper", dack, 8'h20);
    @(negedge clk);
    check("R6 demand back to back", memRd, 1'b1);
    check("R9 tc pulse", tcPulse, 1'b1);
    @(negedge clk);
    check("R9 release after tc", dack, 8'h00);
    dreq[5] = 1'b0;
    regRead(3'd4, 2'd1, b); check("R10 status two bits", b, 8'h22);
    regWrite(3'd4, 2'd1, 8'h00);
    regRead(3'd4, 2'd1, b); check("R10 status cleared", b, 8'h00);

    // R4 priority and slot 4
    writeWord(3'd2, 2'd0, 16'h0200); writeWord(3'd2, 2'd1, 16'h0000);
    regWrite(3'd2, 2'd2, 8'h21);
    writeWord(3'd6, 2'd0, 16'h0600); writeWord(3'd6, 2'd1, 16'h0000);
    regWrite(3'd6, 2'd2, 8'h21);
    expQ.push_back(item(16'h0200, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
    expQ.push_back(item(16'h0600, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0));
    @(negedge clk); dreq = 8'h55;
    idle(12);
    dreq = 8'h00;
    check("R4 priority order", expQ.size(), 0);
    @(negedge clk); dreq[4] = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R4 slot4 never granted", dack, 8'h00);
    end
    dreq[4] = 1'b0;

    // R7 verify mode
    writeWord(3'd3, 2'd0, 16'h0300); writeWord(3'd3, 2'd1, 16'h0001);
    regWrite(3'd3, 2'd2, 8'h24);
    @(negedge clk); dreq[3] = 1'b1;
    idle(8);
    dreq[3] = 1'b0;
    readWord(3'd3, 2'd0, w); check("R7 verify addr", w, 16'h0302);
    readWord(3'd3, 2'd1, w); check("R7 verify count", w, 16'hFFFF);

    // R11 fast limit (ch5 already fast)
    regWrite(3'd0, 2'd2, 8'h10);
    regRead(3'd0, 2'd2, b); check("R11 second fast kept", b, 8'h10);
    regWrite(3'd1, 2'd2, 8'h10);
    regRead(3'd1, 2'd2, b); check("R11 third fast dropped", b, 8'h00);
    regWrite(3'd5, 2'd2, 8'h00);
    regWrite(3'd1, 2'd2, 8'h10);
    regRead(3'd1, 2'd2, b); check("R11 fast after free", b, 8'h10);
    regWrite(3'd0, 2'd2, 8'h00);

    // R10 tc set vs clear in the same cycle
    regWrite(3'd4, 2'd1, 8'h00);
    writeWord(3'd7, 2'd0, 16'h0700); writeWord(3'd7, 2'd1, 16'h0000);
    regWrite(3'd7, 2'd2, 8'h31);
    regRead(3'd7, 2'd2, b); check("R11 fast accepted ch7", b, 8'h31);
    expQ.push_back(item(16'h0700, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0));
    @(negedge clk); dreq[7] = 1'b1;
    @(negedge clk);
    check("R9 tc pulse fast", tcPulse, 1'b1);
    regWr = 1'b1; regAddr = {3'd4, 2'd1}; regWdata = 8'h00;
    @(negedge clk);
    regWr = 1'b0; dreq[7] = 1'b0;
    regRead(3'd4, 2'd1, b); check("R10 set wins over clear", b, 8'h80);
    regWrite(3'd4, 2'd1, 8'h00);
    regRead(3'd4, 2'd1, b); check("R10 later clear", b, 8'h00);

    idle(2);
    check("R7 scoreboard empty", expQ.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule